// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block is a direct-mapped data cache for a single load/store port. Each line holds one block of `WORDS` words, a tag, a valid bit and a dirty bit. The line index is the block address modulo `LINES`, and a hit needs a valid line whose stored tag matches the upper address bits. Stores that hit change only the cached copy and mark the line modified. Memory is updated only when a modified line is pushed out by a conflicting block. A store miss first brings the whole block in and then merges the store word into it.

The processor port takes one request at a time. The cache raises `cpu_stall` whenever it cannot take a new request. It pulses `cpu_rsp_valid` when an access completes, and for a load it drives `cpu_rdata` in that same cycle. The memory side is word-serial. Each beat is held on `mem_req` and `mem_addr` until `mem_ack`, and a block transfer always covers its words in ascending offset order from the block base.

Before a modified line is replaced, its contents are copied into a one-block holding register. With `VICTIM_BUF` set, the refill read of the new block runs first. The held block is then written back in the background while the processor continues. With `VICTIM_BUF` clear, the write-back finishes before the refill starts.

Top module: `dmwb_cache`

## Requirements
- R1: After reset every line is invalid. The first access to any address is a miss, and while idle the block drives `cpu_stall`, `cpu_rsp_valid` and `mem_req` low.
- R2: A load that hits completes one cycle after acceptance. It returns the word last stored to that address, or the memory value if no store was made.
- R3: A store that hits completes one cycle after acceptance. It updates only the cached word, marks the line dirty, and causes no memory write beat.
- R4: A miss reads exactly `WORDS` beats. The beats run in ascending order from the block base, word address = {tag, index, offset}. The dirty bit of the refilled line is cleared.
- R5: Replacing a clean line causes no memory write.
- R6: Replacing a dirty line writes all `WORDS` words of the victim block to the victim's own block address, including every word that was stored.
- R7: With `VICTIM_BUF`=1, a dirty miss completes after only one extra cycle compared with a clean miss. No write beat of the victim occurs before the refill's last read beat.
- R8: A store miss fetches the block, then merges the store word in the completion cycle and marks the line dirty. The other words of the block keep their memory values.
- R9: `cpu_stall` is low only when the controller is idle or is in a compare cycle that hits. A miss completion pulses `cpu_rsp_valid` with `cpu_stall` still high.
- R10: The index is word address bits [OFF_W+IDX_W-1:OFF_W] and the tag is the bits above them. Two addresses with the same index and different tags evict each other.
- R11: A miss that arrives while an earlier victim is still being written back waits until that write-back ends. A reload of the victim's address then returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, taken in a cycle where `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | Cache cannot take a request this cycle |
| cpu_rsp_valid | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_rsp_valid` |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | DATA_W | Write beat data |
| mem_ack | input | 1 | Beat accepted; read data valid on `mem_rdata` |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
The bench memory raises `mem_ack` one cycle after it sees a request, so each beat costs two cycles. Latency is counted at falling edges, starting with the first falling edge after the accepting rising edge. On that count a hit response is due at count 1, a clean miss at 2+2·WORDS and a dirty miss with the holding register at 3+2·WORDS. Each table vector is checked against these values, and idle gaps between vectors let any background write-back drain first so that the counts stay exact. Write and read beat counters and a log of read addresses are sampled at the response edge and again after the gap. This shows that the refill runs before the write-back and that no write occurs on hits or on clean evictions.

// File: rtl/dmwb_pkg.sv
package dmwb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_COMPARE,
    S_VSAVE,
    S_WRITEBACK,
    S_REFILL,
    S_COMPLETE
  } cst_e;
endpackage

// File: rtl/dmwb_store.sv
module dmwb_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        idx,
  input  logic [OFF_W-1:0]        off,
  input  logic [TAG_W-1:0]        cmp_tag,
  output logic                    hit,
  output logic                    line_dirty,
  output logic [TAG_W-1:0]        line_tag,
  output logic [WORDS*DATA_W-1:0] line_blk,
  output logic [DATA_W-1:0]       word_q,
  input  logic                    fill_we,
  input  logic [OFF_W-1:0]        fill_off,
  input  logic [DATA_W-1:0]       fill_data,
  input  logic                    fill_last,
  input  logic                    cpu_we,
  input  logic [DATA_W-1:0]       cpu_data
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES][WORDS];

  // state bits with reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_last) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (cpu_we) dirty_q[idx] <= 1'b1;
    end
  end

  // payload without reset
  always_ff @(posedge clk) begin
    if (fill_we)   data_q[idx][fill_off] <= fill_data;
    if (fill_last) tag_q[idx] <= cmp_tag;
    if (cpu_we)    data_q[idx][off] <= cpu_data;
  end

  assign hit        = valid_q[idx] && (tag_q[idx] == cmp_tag);
  assign line_dirty = valid_q[idx] && dirty_q[idx];
  assign line_tag   = tag_q[idx];
  assign word_q     = data_q[idx][off];

  for (genvar w = 0; w < WORDS; w++) begin : g_blk
    assign line_blk[w*DATA_W +: DATA_W] = data_q[idx][w];
  end

  p_fill_clears_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> !dirty_q[$past(idx)]);

  p_store_marks_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> dirty_q[$past(idx)] && valid_q[$past(idx)]);
endmodule

// File: rtl/dmwb_victim.sv
module dmwb_victim #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int BLK_W  = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BLK_W-1:0]        load_blk,
  input  logic [WORDS*DATA_W-1:0] load_data,
  input  logic                    grant,
  input  logic                    ack,
  output logic                    busy,
  output logic                    req,
  output logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       wdata
);
  logic                    busy_q;
  logic [OFF_W-1:0]        cnt_q;
  logic [BLK_W-1:0]        blk_q;
  logic [WORDS*DATA_W-1:0] data_q;
  logic                    beat_done;

  assign beat_done = busy_q && grant && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      blk_q  <= load_blk;
      data_q <= load_data;
    end else if (beat_done) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == OFF_W'(WORDS-1)) busy_q <= 1'b0;
    end
  end

  assign busy  = busy_q;
  assign req   = busy_q && grant;
  assign addr  = {blk_q, cnt_q};
  assign wdata = data_q[cnt_q*DATA_W +: DATA_W];

  p_load_only_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  p_drain_addr_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && cnt_q != OFF_W'(WORDS-1)) |=> (addr == $past(addr) + 1'b1));
endmodule

// File: rtl/dmwb_cache.sv
module dmwb_cache
  import dmwb_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINES      = 8,
  parameter int WORDS      = 4,
  parameter int VICTIM_BUF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W = ADDR_W - OFF_W;

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_word(input logic [TAG_W-1:0] t,
                                               input logic [IDX_W-1:0] i,
                                               input logic [OFF_W-1:0] o);
    return {t, i, o};
  endfunction

  cst_e st_q, st_d, after_save;

  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [OFF_W-1:0]  fill_cnt;

  logic [IDX_W-1:0] r_idx;
  logic [OFF_W-1:0] r_off;
  logic [TAG_W-1:0] r_tag;

  // named internal events
  logic ev_hit, ev_miss, ready, accept, fill_beat, fill_last, vb_load, cpu_wr;
  logic in_refill;

  // store outputs
  logic                    hit, line_dirty;
  logic [TAG_W-1:0]        line_tag;
  logic [WORDS*DATA_W-1:0] line_blk;
  logic [DATA_W-1:0]       word_q;

  // victim holding register
  logic              vb_busy, vb_req, vb_grant, vb_ack;
  logic [ADDR_W-1:0] vb_addr;
  logic [DATA_W-1:0] vb_wdata;

  assign r_idx = f_idx(r_addr);
  assign r_off = f_off(r_addr);
  assign r_tag = f_tag(r_addr);

  assign in_refill = (st_q == S_REFILL);
  assign ev_hit    = (st_q == S_COMPARE) && hit;
  assign ev_miss   = (st_q == S_COMPARE) && !hit;
  assign ready     = (st_q == S_IDLE) || ev_hit;
  assign accept    = cpu_req && ready;
  assign fill_beat = in_refill && mem_ack;
  assign fill_last = fill_beat && (fill_cnt == OFF_W'(WORDS-1));
  assign vb_load   = (st_q == S_VSAVE);
  assign cpu_wr    = r_we && (ev_hit || (st_q == S_COMPLETE));

  // variant: refill first (holding register frees the port) or write-back first
  if (VICTIM_BUF != 0) begin : g_refill_first
    assign after_save = S_REFILL;
  end else begin : g_wb_first
    assign after_save = S_WRITEBACK;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:      if (accept) st_d = S_COMPARE;
      S_COMPARE: begin
        if (hit)           st_d = accept ? S_COMPARE : S_IDLE;
        else if (!vb_busy) st_d = line_dirty ? S_VSAVE : S_REFILL;
      end
      S_VSAVE:     st_d = after_save;
      S_WRITEBACK: if (!vb_busy) st_d = S_REFILL;
      S_REFILL:    if (fill_last) st_d = S_COMPLETE;
      S_COMPLETE:  st_d = S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      r_we     <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
      fill_cnt <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        r_we    <= cpu_we;
        r_addr  <= cpu_addr;
        r_wdata <= cpu_wdata;
      end
      if (!in_refill)     fill_cnt <= '0;
      else if (fill_beat) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  dmwb_store #(
    .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .TAG_W(TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (r_idx),
    .off       (r_off),
    .cmp_tag   (r_tag),
    .hit       (hit),
    .line_dirty(line_dirty),
    .line_tag  (line_tag),
    .line_blk  (line_blk),
    .word_q    (word_q),
    .fill_we   (fill_beat),
    .fill_off  (fill_cnt),
    .fill_data (mem_rdata),
    .fill_last (fill_last),
    .cpu_we    (cpu_wr),
    .cpu_data  (r_wdata)
  );

  assign vb_grant = !in_refill;
  assign vb_ack   = mem_ack && vb_grant;

  dmwb_victim #(
    .DATA_W(DATA_W), .WORDS(WORDS), .BLK_W(BLK_W)
  ) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (vb_load),
    .load_blk ({line_tag, r_idx}),
    .load_data(line_blk),
    .grant    (vb_grant),
    .ack      (vb_ack),
    .busy     (vb_busy),
    .req      (vb_req),
    .addr     (vb_addr),
    .wdata    (vb_wdata)
  );

  assign mem_req   = in_refill || vb_req;
  assign mem_we    = !in_refill && vb_req;
  assign mem_addr  = in_refill ? f_word(r_tag, r_idx, fill_cnt) : vb_addr;
  assign mem_wdata = vb_wdata;

  assign cpu_stall     = !ready;
  assign cpu_rsp_valid = ev_hit || (st_q == S_COMPLETE);
  assign cpu_rdata     = word_q;

  p_complete_after_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_COMPLETE) |-> ($past(st_q) == S_REFILL));

  p_line_present_at_complete_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_COMPLETE) |-> hit);

  p_stall_with_rsp_only_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && cpu_stall) |-> (st_q == S_COMPLETE));

  p_victim_held_after_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_busy) |-> (st_q == after_save));

  p_miss_waits_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && vb_busy) |=> (st_q == S_COMPARE));

  p_no_write_in_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_refill |-> !mem_we);
endmodule

// File: tb/dmwb_cache_tb.sv
module dmwb_cache_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NW = 4;
  localparam int MEMSZ = 1 << AW;
  localparam int LAT_HIT = 1;
  localparam int LAT_CLEAN = 2 + 2*NW;
  localparam int LAT_DIRTY = 3 + 2*NW;
  localparam int SETTLE = 12;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic [7:0]    lat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h016, 32'h0,         8'(LAT_CLEAN)}, // R1 R4 cold miss
    '{1'b0, 10'h017, 32'h0,         8'(LAT_HIT)},   // R2 hit after fill
    '{1'b1, 10'h015, 32'h1111_0001, 8'(LAT_HIT)},   // R3 store hit
    '{1'b0, 10'h015, 32'h0,         8'(LAT_HIT)},   // R3 read back
    '{1'b0, 10'h0B6, 32'h0,         8'(LAT_DIRTY)}, // R7 dirty miss, same index
    '{1'b0, 10'h0B4, 32'h0,         8'(LAT_HIT)},   // R2 hit on new block
    '{1'b1, 10'h040, 32'h2222_0002, 8'(LAT_CLEAN)}, // R8 store miss
    '{1'b0, 10'h041, 32'h0,         8'(LAT_HIT)},   // R8 neighbour kept
    '{1'b0, 10'h040, 32'h0,         8'(LAT_HIT)},   // R8 merged word
    '{1'b0, 10'h020, 32'h0,         8'(LAT_DIRTY)}, // R6 evict merged block
    '{1'b0, 10'h040, 32'h0,         8'(LAT_CLEAN)}, // R6 comes back from memory
    '{1'b0, 10'h1F3, 32'h0,         8'(LAT_CLEAN)}, // R10 new index 4
    '{1'b0, 10'h3F3, 32'h0,         8'(LAT_CLEAN)}, // R5 R10 clean conflict
    '{1'b0, 10'h1F3, 32'h0,         8'(LAT_CLEAN)}  // R10 conflict again
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_stall, cpu_rsp_valid;
  logic [DW-1:0] cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  always #2 clk = ~clk;

  dmwb_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] f_init(input int i);
    return 32'h3C00_0000 + i * 32'h0001_0003;
  endfunction

  // memory model: acknowledges one cycle after a request
  logic [DW-1:0] mem  [MEMSZ];
  logic [DW-1:0] gold [MEMSZ];
  logic [AW-1:0] rd_log [4];
  int wr_beats, rd_beats;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wr_beats  <= 0;
      rd_beats  <= 0;
      for (int i = 0; i < MEMSZ; i++) mem[i] <= f_init(i);
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          wr_beats <= wr_beats + 1;
        end else begin
          mem_rdata <= mem[mem_addr];
          rd_log[rd_beats[1:0]] <= mem_addr;
          rd_beats <= rd_beats + 1;
        end
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // call at a falling edge; returns at the falling edge of the response
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat, output logic stl);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (cpu_stall) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd  = cpu_rdata;
    stl = cpu_stall;
    if (we) gold[a] = wd;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      report();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    logic stl;
    int wb, rb;
    for (int i = 0; i < MEMSZ; i++) gold[i] = f_init(i);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R9 reset state
    check(cpu_stall == 1'b0, "R1 stall low after reset", 32'(cpu_stall), 32'h0);
    check(cpu_rsp_valid == 1'b0, "R1 no response after reset", 32'(cpu_rsp_valid), 32'h0);
    check(mem_req == 1'b0, "R1 no memory request after reset", 32'(mem_req), 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [DW-1:0] exp_d;
      exp_d = gold[VEC[v].addr];
      access(VEC[v].we, VEC[v].addr, VEC[v].wd, rd, lat, stl);
      check(lat == int'(VEC[v].lat), $sformatf("R2 R4 R7 latency vector %0d", v),
            32'(lat), 32'(VEC[v].lat));
      check(stl == (VEC[v].lat != 8'(LAT_HIT)), $sformatf("R9 stall at response vector %0d", v),
            32'(stl), 32'(VEC[v].lat != 8'(LAT_HIT)));
      if (!VEC[v].we)
        check(rd == exp_d, $sformatf("R2 R8 load data vector %0d", v), rd, exp_d);
      settle();
    end

    // R3 R5: only the two dirty evictions wrote memory
    check(wr_beats == 2*NW, "R3 R5 write beats after table", 32'(wr_beats), 32'(2*NW));
    for (int k = 0; k < NW; k++) begin
      check(mem[10'h014 + k] == gold[10'h014 + k], "R6 first victim block in memory",
            mem[10'h014 + k], gold[10'h014 + k]);
      check(mem[10'h040 + k] == gold[10'h040 + k], "R6 R8 merged block in memory",
            mem[10'h040 + k], gold[10'h040 + k]);
    end

    // R7: refill read goes ahead of the victim write-back
    access(1'b1, 10'h1F0, 32'h3333_0003, rd, lat, stl);
    check(lat == LAT_HIT, "R3 store hit latency", 32'(lat), 32'(LAT_HIT));
    settle();
    wb = wr_beats;
    rb = rd_beats;
    access(1'b0, 10'h3F0, 32'h0, rd, lat, stl);
    check(lat == LAT_DIRTY, "R7 dirty miss latency", 32'(lat), 32'(LAT_DIRTY));
    check(wr_beats == wb, "R7 no write before refill done", 32'(wr_beats), 32'(wb));
    check(rd_beats == rb + NW, "R4 read beat count", 32'(rd_beats), 32'(rb + NW));
    for (int k = 0; k < NW; k++)
      check(rd_log[(rb + k) % 4] == 10'(10'h3F0 + k), "R4 refill address order",
            32'(rd_log[(rb + k) % 4]), 32'(10'h3F0 + k));
    check(rd == gold[10'h3F0], "R2 load data after dirty miss", rd, gold[10'h3F0]);
    settle();
    check(wr_beats == wb + NW, "R6 victim written after refill", 32'(wr_beats), 32'(wb + NW));
    check(mem[10'h1F0] == 32'h3333_0003, "R6 stored word reached memory",
          mem[10'h1F0], 32'h3333_0003);

    // R11: miss to the victim while it is still being written back
    access(1'b1, 10'h3F1, 32'h4444_0004, rd, lat, stl);
    settle();
    access(1'b0, 10'h1F2, 32'h0, rd, lat, stl);
    check(lat == LAT_DIRTY, "R7 dirty miss latency again", 32'(lat), 32'(LAT_DIRTY));
    access(1'b0, 10'h3F1, 32'h0, rd, lat, stl);
    check(rd == 32'h4444_0004, "R11 reload of victim sees stored data", rd, 32'h4444_0004);
    check(lat > LAT_CLEAN, "R11 miss waited for write-back", 32'(lat), 32'(LAT_CLEAN + 1));
    settle();
    check(cpu_stall == 1'b0, "R9 stall low when idle", 32'(cpu_stall), 32'h0);

    done = 1;
    report();
    $finish;
  end
endmodule